// File: doc/BRIEF.md
# Write-Only Serial Control Slave for a Current-Sink DAC

This block is the digital front end of a current-sink driver. It sits on a two-wire I2C bus as a slave that only accepts writes, and it holds one 8-bit control code for the DAC. The DAC converts that code into a sink current. A code of N from 1 to 255 asks for N × 500 µA. A code of 0 switches the sink off. There is no read path: the master can only write the code.

The block runs on a system clock that is at least eight times the fastest SCL rate. Both bus lines pass through a synchronizer and then a majority filter before any edge is decoded. The block drives the data line only as an open-drain pull-down, and only to acknowledge a byte. A master may send any number of data bytes after one matching address byte. Each byte that is acknowledged replaces the code.

Two inputs force the code to zero and return the bus logic to idle: an active-low sleep input and a supply-fault input. The drive-enable output is on only when the code is nonzero, sleep is inactive and no fault is present.

Top module: `csink_i2c_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0x00 and both `drive_en` and `sda_oe` are 0.
- R2: A first byte whose upper five bits are 00011 and whose last bit (R/W) is 0 is acknowledged, whatever its two middle bits are. The accepted bytes are 0x18, 0x1A, 0x1C and 0x1E. The acknowledge is `sda_oe` high during the ninth SCL high phase.
- R3: A first byte with any other upper five bits, or with R/W = 1, is not acknowledged. Every byte after it is also left unacknowledged and does not change the code, up to the next start.
- R4: Data bytes are taken MSB first, sampled on SCL rising edges. Each data byte after a matching address is acknowledged, and after its eighth bit it becomes `dac_code`.
- R5: Several data bytes may follow one address. Each one overwrites the code, so the last byte before the stop is the one that stays.
- R6: A start seen partway through a byte (a repeated start) discards that partial byte and begins a new address phase. A stop seen partway through a byte leaves the code unchanged. After that stop, further bytes are ignored until a start.
- R7: `drive_en` is 1 exactly when `dac_code` is nonzero, `sleep_n` is 1 and `vdd_fault` is 0.
- R8: While `sleep_n` is 0, `dac_code` is held at 0 and no acknowledge is driven. Bytes sent during sleep leave the code at 0.
- R9: While `vdd_fault` is 1, `dac_code` is forced to 0 and any transfer in progress is dropped.
- R10: `sda_oe` rises only while SCL is low: after the falling edge that ends bit 8. It falls after the falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8× the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sleep_n | input | 1 | Active-low sleep; low clears the code and idles the bus logic |
| vdd_fault | input | 1 | Supply fault; high clears the code and aborts any transfer |
| sda_oe | output | 1 | Pulls SDA low when high (acknowledge only) |
| dac_code | output | 8 | Registered DAC control code |
| drive_en | output | 1 | Output sink enable |

## Verification
The hardest states to reach are the bus conditions that break into a byte. A start or stop must arrive while bits are still being shifted, and the block must then either begin a fresh address phase or discard the byte. The bench drives the bus bit by bit, so it can stop partway through a byte and then issue a repeated start or a stop. After a stop, it sends whole bytes with no new start, to show the block stays idle. It also sends a full transfer while sleep is low. In each case it checks at the pins that no acknowledge appears and that the code keeps its value.

// File: rtl/csink_pkg.sv
package csink_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_SKIP = 2'd3
   } xfer_state_e;
endpackage

// File: rtl/csink_in_filter.sv
module csink_in_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   localparam int HALF = FILT_TAPS / 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((FILT_TAPS % 2) == 0 || FILT_TAPS < 3) begin : g_bad_taps
      $error("FILT_TAPS must be odd and at least 3");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_TAPS-1:0]   hist_q;
   logic                   vote;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         hist_q <= '1;
         filt_o <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
         hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
         filt_o <= vote;
      end
   end

   always_comb begin
      int ones;
      ones = 0;
      for (int k = 0; k < FILT_TAPS; k++) begin
         ones = ones + int'(hist_q[k]);
      end
      vote = (ones > HALF);
   end
endmodule

// File: rtl/csink_bus_events.sv
module csink_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop,
   output logic sda_lvl
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      scl_rise  = scl_f & ~scl_q;
      scl_fall  = ~scl_f & scl_q;
      bus_start = scl_f & scl_q & sda_q & ~sda_f;
      bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
      sda_lvl   = sda_f;
   end
endmodule

// File: rtl/csink_xfer_fsm.sv
module csink_xfer_fsm
   import csink_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter int          ADDR_W       = 7,
   parameter int          ADDR_DC_BITS = 2,
   parameter logic [ADDR_W-ADDR_DC_BITS-1:0] ADDR_FIXED = 5'b00011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_clr,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              sda_lvl,
   output logic              ack_oe,
   output logic [DATA_W-1:0] code_q
);
   localparam int CNT_W   = $clog2(DATA_W + 1);
   localparam int FIX_W   = ADDR_W - ADDR_DC_BITS;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   if (ADDR_W + 1 != DATA_W) begin : g_bad_addr
      $error("address plus R/W bit must fill one byte");
   end
   if (ADDR_DC_BITS < 0 || ADDR_DC_BITS >= ADDR_W) begin : g_bad_dc
      $error("ADDR_DC_BITS out of range");
   end

   xfer_state_e       state_q;
   logic [CNT_W-1:0]  bit_q;
   logic              ack_ph_q;
   logic [DATA_W-1:0] shift_q;
   logic              addr_hit;
   logic              in_byte;

   assign addr_hit = (shift_q[DATA_W-1 -: FIX_W] == ADDR_FIXED) && !shift_q[0];
   assign in_byte  = (state_q == ST_ADDR) || (state_q == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         ack_ph_q <= 1'b0;
         shift_q  <= '0;
         ack_oe   <= 1'b0;
         code_q   <= '0;
      end else if (hold_clr) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         ack_ph_q <= 1'b0;
         ack_oe   <= 1'b0;
         code_q   <= '0;
      end else if (bus_start) begin
         state_q  <= ST_ADDR;
         bit_q    <= '0;
         ack_ph_q <= 1'b0;
         ack_oe   <= 1'b0;
      end else if (bus_stop) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         ack_ph_q <= 1'b0;
         ack_oe   <= 1'b0;
      end else if (in_byte) begin
         if (scl_rise && !ack_ph_q && bit_q != LAST_BIT) begin
            shift_q <= {shift_q[DATA_W-2:0], sda_lvl};
            bit_q   <= bit_q + CNT_W'(1);
         end else if (scl_fall && ack_ph_q) begin
            ack_ph_q <= 1'b0;
            bit_q    <= '0;
            ack_oe   <= 1'b0;
            state_q  <= ack_oe ? ST_DATA : ST_SKIP;
         end else if (scl_fall && bit_q == LAST_BIT) begin
            ack_ph_q <= 1'b1;
            if (state_q == ST_ADDR) begin
               ack_oe <= addr_hit;
            end else begin
               ack_oe <= 1'b1;
               code_q <= shift_q;
            end
         end
      end
   end
endmodule

// File: rtl/csink_i2c_ctrl.sv
module csink_i2c_ctrl #(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 7,
   parameter int ADDR_DC_BITS = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int FILT_TAPS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              sleep_n,
   input  logic              vdd_fault,
   output logic              sda_oe,
   output logic [DATA_W-1:0] dac_code,
   output logic              drive_en
);
   logic scl_f, sda_f;
   logic scl_rise, scl_fall, bus_start, bus_stop, sda_lvl;
   logic hold_clr;

   assign hold_clr = !sleep_n || vdd_fault;

   csink_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f)
   );
   csink_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f)
   );

   csink_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop), .sda_lvl(sda_lvl)
   );

   csink_xfer_fsm #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_DC_BITS(ADDR_DC_BITS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .hold_clr(hold_clr),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop), .sda_lvl(sda_lvl),
      .ack_oe(sda_oe), .code_q(dac_code)
   );

   assign drive_en = (dac_code != '0) && sleep_n && !vdd_fault;
endmodule

// File: rtl/csink_i2c_ctrl_chk.sv
module csink_i2c_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sleep_n,
   input logic              vdd_fault,
   input logic              sda_oe,
   input logic [DATA_W-1:0] dac_code,
   input logic              drive_en
);
   // R7: zero code never enables the sink
   a_r7_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_code == '0) |-> !drive_en);

   // R8: sleep clears the code and suppresses acknowledge
   a_r8_sleep_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (dac_code == '0) && !sda_oe);

   // R9: supply fault clears the code
   a_r9_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
      vdd_fault |=> (dac_code == '0));

   // R4: a nonzero code change only happens together with a data acknowledge
   a_r4_load_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dac_code) && dac_code != '0) |-> $rose(sda_oe));

   // R10: acknowledge drive starts only while SCL is low
   a_r10_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);
endmodule

bind csink_i2c_ctrl csink_i2c_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sleep_n(sleep_n),
   .vdd_fault(vdd_fault), .sda_oe(sda_oe), .dac_code(dac_code),
   .drive_en(drive_en)
);

// File: tb/csink_i2c_ctrl_test.sv
module csink_i2c_ctrl_test;
   localparam int H  = 20;
   localparam int NV = 9;
   // {address byte, data byte, expect acknowledge}
   localparam logic [16:0] VEC [NV] = '{
      {8'h18, 8'h01, 1'b1}, {8'h1A, 8'h80, 1'b1}, {8'h1C, 8'hFF, 1'b1},
      {8'h1E, 8'h5A, 1'b1}, {8'h10, 8'h33, 1'b0}, {8'h19, 8'h44, 1'b0},
      {8'h38, 8'h11, 1'b0}, {8'h18, 8'h00, 1'b1}, {8'h1A, 8'hA5, 1'b1}
   };

   logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, sleep_n = 1, fault = 0;
   logic sda_oe, drive_en;
   logic [7:0] dac_code;
   logic sda_w;
   int checks = 0, failures = 0;
   logic [7:0] model = 8'h00;
   logic ack;

   assign sda_w = sda_m & ~sda_oe;
   always #5 clk = ~clk;

   csink_i2c_ctrl uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w),
      .sleep_n(sleep_n), .vdd_fault(fault),
      .sda_oe(sda_oe), .dac_code(dac_code), .drive_en(drive_en)
   );

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_m = 1; waitc(H);
      scl = 1;   waitc(H);
      sda_m = 0; waitc(H);
      scl = 0;   waitc(H/4);
   endtask

   task automatic bus_stop;
      sda_m = 0; waitc(H);
      scl = 1;   waitc(H);
      sda_m = 1; waitc(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; waitc(H);
         scl = 1;      waitc(H);
         scl = 0;      waitc(H/4);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic a);
      send_bits(b, 8);
      sda_m = 1; waitc(H);
      scl = 1;   waitc(H/2);
      a = sda_oe;
      waitc(H/2);
      scl = 0;   waitc(H);
   endtask

   initial begin
      waitc(150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      waitc(3);
      chk("R1 code", dac_code, 0);
      chk("R1 drive_en", drive_en, 0);
      chk("R1 sda_oe", sda_oe, 0);
      rst_n = 1; waitc(10);

      for (int v = 0; v < NV; v++) begin
         logic [7:0] ad, dt;
         logic ea;
         {ad, dt, ea} = VEC[v];
         bus_start;
         send_byte(ad, ack);
         chk(ea ? "R2 addr ack" : "R3 addr nack", ack, ea);
         send_byte(dt, ack);
         chk(ea ? "R4 data ack" : "R3 data nack", ack, ea);
         bus_stop; waitc(H);
         if (ea) model = dt;
         chk("R4 code", dac_code, model);
         chk("R7 drive_en", drive_en, model != 0);
      end

      // R5: several bytes in one transfer
      bus_start; send_byte(8'h1C, ack);
      send_byte(8'h11, ack); chk("R5 first byte ack", ack, 1);
      chk("R5 first byte code", dac_code, 8'h11);
      send_byte(8'h22, ack);
      send_byte(8'h7E, ack); chk("R5 third byte ack", ack, 1);
      bus_stop; waitc(H);
      chk("R5 last byte kept", dac_code, 8'h7E);

      // R6: repeated start in the middle of a data byte
      bus_start; send_byte(8'h18, ack);
      send_bits(8'hC3, 4);
      bus_start; send_byte(8'h1E, ack);
      chk("R6 restart addr ack", ack, 1);
      send_byte(8'h09, ack); bus_stop; waitc(H);
      chk("R6 restart code", dac_code, 8'h09);

      // R6: stop in the middle of a byte, then bytes with no start
      bus_start; send_byte(8'h18, ack);
      send_bits(8'hF0, 4);
      bus_stop; waitc(H);
      chk("R6 partial byte dropped", dac_code, 8'h09);
      scl = 0; waitc(H);
      send_byte(8'h18, ack); chk("R6 no ack without start", ack, 0);
      send_byte(8'h55, ack); chk("R6 idle data nack", ack, 0);
      bus_stop; waitc(H);
      chk("R6 code unchanged", dac_code, 8'h09);

      // R3: after a miss, later bytes ignored even if they look like an address
      bus_start; send_byte(8'h1B, ack); chk("R3 read bit nack", ack, 0);
      send_byte(8'h18, ack); chk("R3 skip nack", ack, 0);
      bus_stop; waitc(H);
      chk("R3 code unchanged", dac_code, 8'h09);

      // R8: sleep
      sleep_n = 0; waitc(3);
      chk("R8 sleep code", dac_code, 0);
      chk("R7 sleep drive_en", drive_en, 0);
      bus_start; send_byte(8'h18, ack); chk("R8 no ack in sleep", ack, 0);
      send_byte(8'h66, ack); bus_stop; waitc(H);
      chk("R8 code held zero", dac_code, 0);
      sleep_n = 1; waitc(H);

      // R9: fault during transfer
      bus_start; send_byte(8'h1A, ack); send_byte(8'h44, ack);
      chk("R9 preload", dac_code, 8'h44);
      send_bits(8'hFF, 3);
      fault = 1; waitc(3);
      chk("R9 fault code", dac_code, 0);
      chk("R7 fault drive_en", drive_en, 0);
      fault = 0; waitc(2);
      send_bits(8'hFF, 5);
      sda_m = 1; waitc(H); scl = 1; waitc(H/2);
      chk("R9 transfer dropped", sda_oe, 0);
      waitc(H/2); scl = 0; waitc(H);
      bus_stop; waitc(H);
      chk("R9 code stays zero", dac_code, 0);

      // R10: acknowledge released after ninth clock
      bus_start; send_byte(8'h18, ack); send_byte(8'h3C, ack);
      chk("R10 oe released", sda_oe, 0);
      bus_stop; waitc(H);
      chk("R10 code", dac_code, 8'h3C);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule